// File: doc/BRIEF.md
# Set/Clear Aliased Interrupt Control Register

This block holds one 64-bit control word behind a small word-addressed register port. Software reaches the word through three neighbouring word addresses. The first replaces the contents and is the only one that can be read. The second combines the contents with the write data by bitwise AND. The third combines them by bitwise OR. A build-time variant turns the second alias into a blanket clear that ignores its data. Only the top 19 bits of the word are storage; every lower bit reads as zero whatever is written.

The most significant bit drives a level interrupt line directly. A hardware request input sets that bit and the message bit three places below it in a single update, so on-chip logic can post a message and raise the line without a bus cycle. When a bus write and a request land in the same cycle, the bus operation is applied first and the request bits are then ORed on top.

The port carries byte addresses. The word address is the byte address shifted right by three, so only whole 8-byte accesses have meaning. The port is a plain control port: an access is accepted in the cycle `acc_en` is high, there is no back-pressure, and a read returns its data one cycle later with `rd_valid_o`. Any other word address is outside the block: reads return zero, writes do nothing, and each such access raises `unimp_o` for one cycle.

Top module: `alias_irq_reg`

## Requirements
- R1: After reset the stored word is zero, `irq_o` is low, and a read of the base word returns zero.
- R2: Only bits 63 down to 45 are stored (mask 64'hFFFF_E000_0000_0000); bits 44 down to 0 always read as zero, whatever data is written.
- R3: A write at word BASE_WORD replaces the word with the masked write data; a read at BASE_WORD returns the word on `rd_data_o` with `rd_valid_o` high in the following cycle.
- R4: With CLEAR_VARIANT = 0, a write at word BASE_WORD+1 stores the current word ANDed with the write data.
- R5: With CLEAR_VARIANT = 1, a write at word BASE_WORD+1 zeroes the whole word and the write data has no effect.
- R6: A write at word BASE_WORD+2 stores the current word ORed with the masked write data.
- R7: `irq_o` equals stored bit 63 after every update, so it rises and falls with writes that set or clear that bit.
- R8: A cycle with `raise_i` high sets bits 63 and 60 together and leaves the other bits unchanged.
- R9: When a write and `raise_i` occur in the same cycle, the result is the write's outcome ORed with bits 63 and 60.
- R10: Reads of any other word (including BASE_WORD+1 and BASE_WORD+2) return zero, writes to any other word leave the stored word unchanged, and each such access drives `unimp_o` high for exactly the next cycle.
- R11: The word address is the byte address shifted right by three; the low three address bits do not affect which word is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | DATA_W | Write data |
| raise_i | input | 1 | Hardware request to set the interrupt and message bits |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | DATA_W | Read data |
| unimp_o | output | 1 | One-cycle flag after an access to an unserved word |
| irq_o | output | 1 | Level interrupt, copy of stored bit 63 |

## Verification
The bench builds two copies side by side on shared inputs: one with CLEAR_VARIANT = 0 at base word 0x4020, and one with CLEAR_VARIANT = 1 at base word 0x6080. The first brings the AND alias, masking and the unserved-offset path within reach; the second brings the data-ignoring clear alias. Because the bases differ, every access to one copy is an unserved access to the other, so each write also checks that a foreign address leaves a word untouched, while the shared request input checks that both copies raise identically.

// File: rtl/alias_irq_pkg.sv
package alias_irq_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_READ   = 3'd1,
    OP_DIRECT = 3'd2,
    OP_AND    = 3'd3,
    OP_OR     = 3'd4,
    OP_UNIMP  = 3'd5
  } op_kind_e;

  // Offsets of the aliases above the base word; the order is decoded behaviour.
  localparam int unsigned ALIAS_DIRECT = 0;
  localparam int unsigned ALIAS_AND    = 1;
  localparam int unsigned ALIAS_OR     = 2;

  // Big-endian numbering of the two request bits (0 is the MSB).
  localparam int unsigned BE_IRQ_BIT = 0;
  localparam int unsigned BE_MSG_BIT = 3;

endpackage

// File: rtl/alias_irq_decode.sv
module alias_irq_decode
  import alias_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BASE_WORD = 'h4020
) (
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  output op_kind_e          op
);
  localparam int unsigned WA_W = ADDR_W - 3;

  logic [WA_W-1:0] word;
  logic            unused_low;
  logic            hit_direct, hit_and, hit_or;

  assign word       = acc_addr[ADDR_W-1:3];
  assign unused_low = ^acc_addr[2:0];

  assign hit_direct = (word == WA_W'(BASE_WORD + ALIAS_DIRECT));
  assign hit_and    = (word == WA_W'(BASE_WORD + ALIAS_AND));
  assign hit_or     = (word == WA_W'(BASE_WORD + ALIAS_OR));

  always_comb begin
    op = OP_NONE;
    if (acc_en) begin
      if (!acc_we) begin
        op = hit_direct ? OP_READ : OP_UNIMP;
      end else if (hit_direct) begin
        op = OP_DIRECT;
      end else if (hit_and) begin
        op = OP_AND;
      end else if (hit_or) begin
        op = OP_OR;
      end else begin
        op = OP_UNIMP;
      end
    end
  end

endmodule

// File: rtl/alias_irq_next.sv
module alias_irq_next
  import alias_irq_pkg::*;
#(
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned IMPL_BITS     = 19,
  parameter bit          CLEAR_VARIANT = 1'b0
) (
  input  logic [DATA_W-1:0] cur,
  input  op_kind_e          op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              raise,
  output logic [DATA_W-1:0] nxt,
  output logic              upd
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{IMPL_BITS{1'b1}}, {(DATA_W-IMPL_BITS){1'b0}}};
  localparam logic [DATA_W-1:0] RAISE_SET =
    (DATA_W'(1) << (DATA_W-1-BE_IRQ_BIT)) | (DATA_W'(1) << (DATA_W-1-BE_MSG_BIT));

  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] and_res;
  logic [DATA_W-1:0] bus_res;

  assign wmask = wdata & KEEP_MASK;

  generate
    if (CLEAR_VARIANT) begin : g_clear
      logic unused_cur;
      assign unused_cur = ^cur[0];
      assign and_res    = '0;
    end else begin : g_and
      assign and_res = cur & wmask;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_DIRECT: bus_res = wmask;
      OP_AND:    bus_res = and_res;
      OP_OR:     bus_res = (cur | wmask) & KEEP_MASK;
      default:   bus_res = cur;
    endcase
    nxt = raise ? (bus_res | RAISE_SET) : bus_res;
    upd = raise || (op == OP_DIRECT) || (op == OP_AND) || (op == OP_OR);
  end

endmodule

// File: rtl/alias_irq_reg.sv
module alias_irq_reg
  import alias_irq_pkg::*;
#(
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned IMPL_BITS     = 19,
  parameter int unsigned BASE_WORD     = 'h4020,
  parameter bit          CLEAR_VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              raise_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              unimp_o,
  output logic              irq_o
);
  op_kind_e          op;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] ctl_d;
  logic              ctl_upd;

  alias_irq_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_WORD (BASE_WORD)
  ) u_dec (
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .op       (op)
  );

  alias_irq_next #(
    .DATA_W        (DATA_W),
    .IMPL_BITS     (IMPL_BITS),
    .CLEAR_VARIANT (CLEAR_VARIANT)
  ) u_next (
    .cur   (ctl_q),
    .op    (op),
    .wdata (acc_wdata),
    .raise (raise_i),
    .nxt   (ctl_d),
    .upd   (ctl_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_upd) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      unimp_o    <= 1'b0;
    end else begin
      rd_valid_o <= acc_en && !acc_we;
      rd_data_o  <= (op == OP_READ) ? ctl_q : '0;
      unimp_o    <= (op == OP_UNIMP);
    end
  end

  assign irq_o = ctl_q[DATA_W-1-BE_IRQ_BIT];

endmodule

// File: rtl/alias_irq_chk.sv
module alias_irq_chk
  import alias_irq_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned IMPL_BITS = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_we,
  input logic              wdata_msb,
  input logic              raise_i,
  input op_kind_e          op,
  input logic [DATA_W-1:0] ctl_q,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              unimp_o,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] LOW_MASK = {{IMPL_BITS{1'b0}}, {(DATA_W-IMPL_BITS){1'b1}}};

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & LOW_MASK) == '0); // R2

  AST_DIRECT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIRECT && !raise_i) |=> (irq_o == $past(wdata_msb))); // R7

  AST_RAISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> irq_o); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_en && acc_we) && !raise_i) |=> $stable(ctl_q)); // R10

  AST_UNIMP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && unimp_o) |-> (rd_data_o == '0)); // R10

  AST_UNIMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UNIMP) |=> unimp_o); // R10

endmodule

bind alias_irq_reg alias_irq_chk #(
  .DATA_W    (DATA_W),
  .IMPL_BITS (IMPL_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_we     (acc_we),
  .wdata_msb  (acc_wdata[DATA_W-1]),
  .raise_i    (raise_i),
  .op         (op),
  .ctl_q      (ctl_q),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .unimp_o    (unimp_o),
  .irq_o      (irq_o)
);

// File: tb/alias_irq_reg_test.sv
module alias_irq_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int BASE_A = 'h4020;
  localparam int BASE_B = 'h6080;
  localparam logic [63:0] MASK = 64'hFFFF_E000_0000_0000;
  localparam logic [63:0] RBITS = 64'h9000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_we = 1'b0, raise_i = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic rv_a, un_a, irq_a, rv_b, un_b, irq_b;
  logic [63:0] rd_a, rd_b;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_irq_reg #(.BASE_WORD(BASE_A), .CLEAR_VARIANT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .raise_i(raise_i), .rd_valid_o(rv_a), .rd_data_o(rd_a),
    .unimp_o(un_a), .irq_o(irq_a));

  alias_irq_reg #(.BASE_WORD(BASE_B), .CLEAR_VARIANT(1'b1)) uut_v2 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .raise_i(raise_i), .rd_valid_o(rv_b), .rd_data_o(rd_b),
    .unimp_o(un_b), .irq_o(irq_b));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] baddr(int word, int low);
    return AW'((word << 3) | low);
  endfunction

  task automatic wr(int word, logic [63:0] d, logic rs);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = baddr(word, 0); acc_wdata = d; raise_i = rs;
    @(posedge clk); #1;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; raise_i = 1'b0; acc_wdata = '0;
  endtask

  task automatic pulse_raise();
    @(negedge clk); raise_i = 1'b1;
    @(negedge clk); raise_i = 1'b0;
  endtask

  // Read one word; returns both instances' data and unimp flags seen after the edge.
  task automatic rd(logic [AW-1:0] a, output logic [63:0] da, output logic [63:0] db,
                    output logic ua, output logic ub, output logic va);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(posedge clk); #1;
    da = rd_a; db = rd_b; ua = un_a; ub = un_b; va = rv_a;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] da, db; logic ua, ub, va;
    check("R1 irq_a", 64'(irq_a), 0);
    check("R1 irq_b", 64'(irq_b), 0);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R1 read A", da, 0);
    check("R3 valid", 64'(va), 1);
    rd(baddr(BASE_B, 0), da, db, ua, ub, va);
    check("R1 read B", db, 0);
  endtask

  task automatic t_direct();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_A, '1, 1'b0);
    check("R7 irq after direct", 64'(irq_a), 1);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R2 R3 masked read", da, MASK);
    check("R10 other addr read zero", db, 0);
    check("R10 unimp on B", 64'(ub), 1);
    check("R10 no unimp on A", 64'(ua), 0);
    rd(baddr(BASE_B, 0), da, db, ua, ub, va);
    check("R10 B untouched by A write", db, 0);
  endtask

  task automatic t_and();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_A + 1, 64'h8000_0000_0000_FFFF, 1'b0);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R4 and alias", da, 64'h8000_0000_0000_0000);
    check("R7 irq held", 64'(irq_a), 1);
    wr(BASE_A + 1, 64'h0, 1'b0);
    check("R7 irq falls", 64'(irq_a), 0);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R4 and to zero", da, 0);
  endtask

  task automatic t_clear_variant();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_B, 64'hF0F0_F000_0000_0000, 1'b0);
    rd(baddr(BASE_B, 0), da, db, ua, ub, va);
    check("R2 B masked", db, 64'hF0F0_E000_0000_0000);
    check("R7 B irq", 64'(irq_b), 1);
    wr(BASE_B + 1, '1, 1'b0);
    rd(baddr(BASE_B, 0), da, db, ua, ub, va);
    check("R5 clear ignores data", db, 0);
    check("R7 B irq cleared", 64'(irq_b), 0);
  endtask

  task automatic t_or();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_A + 2, 64'h0000_3000_0000_00FF, 1'b0);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R6 or masked", da, 64'h0000_2000_0000_0000);
    check("R7 irq low", 64'(irq_a), 0);
    wr(BASE_A + 2, 64'h8000_0000_0000_0000, 1'b0);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R6 or accumulates", da, 64'h8000_2000_0000_0000);
    check("R7 irq rises", 64'(irq_a), 1);
  endtask

  task automatic t_raise();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_A, 64'h0000_2000_0000_0000, 1'b0);
    pulse_raise();
    check("R8 irq A", 64'(irq_a), 1);
    check("R8 irq B", 64'(irq_b), 1);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R8 A bits", da, 64'h9000_2000_0000_0000);
    rd(baddr(BASE_B, 0), da, db, ua, ub, va);
    check("R8 B bits", db, RBITS);
  endtask

  task automatic t_simul();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_A, 64'h0400_0000_0000_0000, 1'b1);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R9 direct plus raise", da, 64'h9400_0000_0000_0000);
    wr(BASE_A + 1, 64'h0, 1'b1);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R9 and-zero plus raise", da, RBITS);
    wr(BASE_B + 1, 64'h0, 1'b1);
    rd(baddr(BASE_B, 0), da, db, ua, ub, va);
    check("R9 clear plus raise", db, RBITS);
  endtask

  task automatic t_unimp();
    logic [63:0] da, db; logic ua, ub, va;
    wr(BASE_A, 64'h0, 1'b0);
    rd(baddr(BASE_A + 16, 0), da, db, ua, ub, va);
    check("R10 read unserved zero", da, 0);
    check("R10 unimp pulse", 64'(ua), 1);
    @(posedge clk); #1;
    check("R10 unimp one cycle", 64'(un_a), 0);
    wr(BASE_A + 16, '1, 1'b0);
    check("R10 irq unchanged", 64'(irq_a), 0);
    rd(baddr(BASE_A, 0), da, db, ua, ub, va);
    check("R10 write ignored", da, 0);
    wr(BASE_A, 64'hA000_0000_0000_0000, 1'b0);
    rd(baddr(BASE_A + 1, 0), da, db, ua, ub, va);
    check("R10 and alias reads zero", da, 0);
    check("R10 and alias read flagged", 64'(ua), 1);
  endtask

  task automatic t_lowbits();
    logic [63:0] da, db; logic ua, ub, va;
    rd(baddr(BASE_A, 5), da, db, ua, ub, va);
    check("R11 low bits ignored", da, 64'hA000_0000_0000_0000);
    check("R11 no unimp", 64'(ua), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_direct();
    t_and();
    t_clear_variant();
    t_or();
    t_raise();
    t_simul();
    t_unimp();
    t_lowbits();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule